// File: doc/BRIEF.md
# Parallel Copy SIMD Execution Unit

This unit executes three 128-bit data-movement instructions against a private file of 32 split registers. Each register holds a 64-bit lower half and a 64-bit upper half. One 32-bit instruction word arrives with a valid strobe. The unit reads its two source registers in the same cycle and writes both halves of the destination on the next clock edge. The write it commits appears on a registered write-report bus.

The unit supports three operations:
- A halfword broadcast spreads the lowest 16 bits of each source half across that half.
- A lower-doubleword pack joins the lower halves of two sources.
- An upper-doubleword pack joins the upper halves of two sources.

Anything else the unit is handed raises a one-cycle reserved-instruction flag, and nothing is written. A fill port lets neighbouring units deposit results into the same register file. A registered debug port reads out any register.

Top module: `pcopy_simd_unit`

## Requirements
- R1: After synchronous reset every register reads zero in both halves, and `wr_en` and `exc_ri` are low.
- R2: Broadcast encoding: word[31:26]=0x1C, word[5:0]=0x29, word[10:6]=0x1B and word[25:21]=0. Its result's lower half is four copies of bits 15:0 of the lower half of the register named by word[20:16]. Its upper half is four copies of bits 15:0 of that register's upper half.
- R3: A broadcast encoding whose word[25:21] is nonzero raises `exc_ri` and writes nothing, even when word[15:11] is 0.
- R4: Lower pack encoding: word[31:26]=0x1C, word[5:0]=0x09, word[10:6]=0x0E. The destination's lower half takes the lower half of register word[20:16], and its upper half takes the lower half of register word[25:21].
- R5: Upper pack encoding: word[31:26]=0x1C, word[5:0]=0x29, word[10:6]=0x0E. The destination's upper half takes the upper half of register word[20:16], and its lower half takes the upper half of register word[25:21].
- R6: A valid operation whose destination field word[15:11] is 0 changes no register, leaves `wr_en` low and raises no flag. Register 0 also ignores the fill port.
- R7: A source field equal to 0 supplies zero in both halves.
- R8: A word with a major field other than 0x1C, a class other than 0x09 or 0x29, or a sub-operation not listed for its class raises `exc_ri` without `wr_en`.
- R9: `wr_en`, `wr_addr`, `wr_lo`, `wr_hi` and `exc_ri` change on the edge that consumes a valid word. They are low on every cycle after a cycle without a valid word. The next word may read a register written by the previous one.
- R10: `dbg_lo` and `dbg_hi` show register `dbg_addr` one clock after it is presented.
- R11: A fill and an instruction may write in the same cycle. When they name the same register, the instruction's result is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word valid this cycle |
| insn_word | input | 32 | Instruction word |
| fill_en | input | 1 | Fill write enable |
| fill_addr | input | 5 | Fill destination register |
| fill_lo | input | HALF_W | Fill data, lower half |
| fill_hi | input | HALF_W | Fill data, upper half |
| dbg_addr | input | 5 | Debug read register |
| dbg_lo | output | HALF_W | Debug read, lower half (registered) |
| dbg_hi | output | HALF_W | Debug read, upper half (registered) |
| wr_en | output | 1 | An instruction result was written |
| wr_addr | output | 5 | Register that was written |
| wr_lo | output | HALF_W | Written lower half |
| wr_hi | output | HALF_W | Written upper half |
| exc_ri | output | 1 | Reserved-instruction pulse |

## Verification
The checker attributes each output to the word seen one edge earlier. It therefore assumes that `insn_valid` and `insn_word` are steady across each rising edge and that `insn_valid` is low while reset is held. The register-zero check assumes nothing but the unit itself can reach register 0. The bench changes every input only at the falling edge and holds the valid strobe low through reset. It issues debug reads only while no write to the same register is in flight, so the value read is settled.

// File: rtl/pcopy_pkg.sv
package pcopy_pkg;
  localparam int INSN_W = 32;
  localparam int FLD_W  = 5;
  localparam int SUB_W  = 5;
  localparam int CLS_W  = 6;
  localparam int MAJ_W  = 6;

  // field positions (decoded by this unit)
  localparam int RS_LSB  = 21;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;
  localparam int SUB_LSB = 6;
  localparam int MAJ_LSB = 26;

  localparam logic [MAJ_W-1:0] MAJ_MEDIA  = 6'h1C;
  localparam logic [CLS_W-1:0] CLS_GRP_B  = 6'h09;
  localparam logic [CLS_W-1:0] CLS_GRP_C  = 6'h29;
  localparam logic [SUB_W-1:0] SUB_SPREAD = 5'h1B;
  localparam logic [SUB_W-1:0] SUB_PACK   = 5'h0E;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_SPREAD = 2'd1,
    OP_LPACK  = 2'd2,
    OP_UPACK  = 2'd3
  } pc_op_e;
endpackage

// File: rtl/pcopy_decoder.sv
module pcopy_decoder
  import pcopy_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output pc_op_e            op,
  output logic              reserved,
  output logic [FLD_W-1:0]  rs_idx,
  output logic [FLD_W-1:0]  rt_idx,
  output logic [FLD_W-1:0]  rd_idx
);
  logic [MAJ_W-1:0] maj;
  logic [SUB_W-1:0] sub;
  logic [CLS_W-1:0] cls;

  assign maj    = insn[MAJ_LSB +: MAJ_W];
  assign rs_idx = insn[RS_LSB  +: FLD_W];
  assign rt_idx = insn[RT_LSB  +: FLD_W];
  assign rd_idx = insn[RD_LSB  +: FLD_W];
  assign sub    = insn[SUB_LSB +: SUB_W];
  assign cls    = insn[0 +: CLS_W];

  always_comb begin
    op = OP_NONE;
    if (maj == MAJ_MEDIA) begin
      if (cls == CLS_GRP_B) begin
        if (sub == SUB_PACK) op = OP_LPACK;
      end else if (cls == CLS_GRP_C) begin
        if (sub == SUB_SPREAD) begin
          // source field must be zero, otherwise reserved
          if (rs_idx == '0) op = OP_SPREAD;
        end else if (sub == SUB_PACK) begin
          op = OP_UPACK;
        end
      end
    end
  end

  assign reserved = (op == OP_NONE);
endmodule

// File: rtl/pcopy_regfile.sv
module pcopy_regfile #(
  parameter int HALF_W = 64,
  parameter int AW     = 5
) (
  input  logic              clk,
  input  logic              rst,
  // instruction write (wins on address clash)
  input  logic              iw_en,
  input  logic [AW-1:0]     iw_addr,
  input  logic [HALF_W-1:0] iw_lo,
  input  logic [HALF_W-1:0] iw_hi,
  // fill write
  input  logic              fw_en,
  input  logic [AW-1:0]     fw_addr,
  input  logic [HALF_W-1:0] fw_lo,
  input  logic [HALF_W-1:0] fw_hi,
  // combinational source reads
  input  logic [AW-1:0]     ra_s,
  input  logic [AW-1:0]     ra_t,
  output logic [HALF_W-1:0] s_lo,
  output logic [HALF_W-1:0] s_hi,
  output logic [HALF_W-1:0] t_lo,
  output logic [HALF_W-1:0] t_hi,
  // registered debug read
  input  logic [AW-1:0]     ra_d,
  output logic [HALF_W-1:0] d_lo,
  output logic [HALF_W-1:0] d_hi
);
  localparam int NREGS = 1 << AW;

  logic [HALF_W-1:0] lo_mem [NREGS];
  logic [HALF_W-1:0] hi_mem [NREGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREGS; i++) begin
        lo_mem[i] <= '0;
        hi_mem[i] <= '0;
      end
    end else begin
      if (fw_en && fw_addr != '0) begin
        lo_mem[fw_addr] <= fw_lo;
        hi_mem[fw_addr] <= fw_hi;
      end
      if (iw_en && iw_addr != '0) begin
        lo_mem[iw_addr] <= iw_lo;
        hi_mem[iw_addr] <= iw_hi;
      end
    end
  end

  assign s_lo = (ra_s == '0) ? '0 : lo_mem[ra_s];
  assign s_hi = (ra_s == '0) ? '0 : hi_mem[ra_s];
  assign t_lo = (ra_t == '0) ? '0 : lo_mem[ra_t];
  assign t_hi = (ra_t == '0) ? '0 : hi_mem[ra_t];

  always_ff @(posedge clk) begin
    if (rst) begin
      d_lo <= '0;
      d_hi <= '0;
    end else begin
      d_lo <= lo_mem[ra_d];
      d_hi <= hi_mem[ra_d];
    end
  end
endmodule

// File: rtl/pcopy_lanes.sv
module pcopy_lanes
  import pcopy_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int LANE_W = 16
) (
  input  pc_op_e            op,
  input  logic [HALF_W-1:0] s_lo,
  input  logic [HALF_W-1:0] s_hi,
  input  logic [HALF_W-1:0] t_lo,
  input  logic [HALF_W-1:0] t_hi,
  output logic [HALF_W-1:0] r_lo,
  output logic [HALF_W-1:0] r_hi
);
  localparam int LANES = HALF_W / LANE_W;

  logic [HALF_W-1:0] spread_lo;
  logic [HALF_W-1:0] spread_hi;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign spread_lo[g*LANE_W +: LANE_W] = t_lo[LANE_W-1:0];
    assign spread_hi[g*LANE_W +: LANE_W] = t_hi[LANE_W-1:0];
  end

  always_comb begin
    unique case (op)
      OP_SPREAD: begin r_lo = spread_lo; r_hi = spread_hi; end
      OP_LPACK:  begin r_lo = t_lo;      r_hi = s_lo;      end
      OP_UPACK:  begin r_lo = s_hi;      r_hi = t_hi;      end
      default:   begin r_lo = '0;        r_hi = '0;        end
    endcase
  end
endmodule

// File: rtl/pcopy_simd_unit.sv
module pcopy_simd_unit
  import pcopy_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int LANE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              insn_valid,
  input  logic [31:0]       insn_word,
  input  logic              fill_en,
  input  logic [4:0]        fill_addr,
  input  logic [HALF_W-1:0] fill_lo,
  input  logic [HALF_W-1:0] fill_hi,
  input  logic [4:0]        dbg_addr,
  output logic [HALF_W-1:0] dbg_lo,
  output logic [HALF_W-1:0] dbg_hi,
  output logic              wr_en,
  output logic [4:0]        wr_addr,
  output logic [HALF_W-1:0] wr_lo,
  output logic [HALF_W-1:0] wr_hi,
  output logic              exc_ri
);
  localparam int AW = FLD_W;

  pc_op_e            dec_op;
  logic              dec_rsv;
  logic [AW-1:0]     rs_idx, rt_idx, rd_idx;
  logic [HALF_W-1:0] s_lo, s_hi, t_lo, t_hi;
  logic [HALF_W-1:0] res_lo, res_hi;
  logic              commit;

  pcopy_decoder u_dec (
    .insn     (insn_word),
    .op       (dec_op),
    .reserved (dec_rsv),
    .rs_idx   (rs_idx),
    .rt_idx   (rt_idx),
    .rd_idx   (rd_idx)
  );

  assign commit = insn_valid && !dec_rsv && (rd_idx != '0);

  pcopy_regfile #(.HALF_W(HALF_W), .AW(AW)) u_rf (
    .clk     (clk),
    .rst     (rst),
    .iw_en   (commit),
    .iw_addr (rd_idx),
    .iw_lo   (res_lo),
    .iw_hi   (res_hi),
    .fw_en   (fill_en),
    .fw_addr (fill_addr),
    .fw_lo   (fill_lo),
    .fw_hi   (fill_hi),
    .ra_s    (rs_idx),
    .ra_t    (rt_idx),
    .s_lo    (s_lo),
    .s_hi    (s_hi),
    .t_lo    (t_lo),
    .t_hi    (t_hi),
    .ra_d    (dbg_addr),
    .d_lo    (dbg_lo),
    .d_hi    (dbg_hi)
  );

  pcopy_lanes #(.HALF_W(HALF_W), .LANE_W(LANE_W)) u_lanes (
    .op   (dec_op),
    .s_lo (s_lo),
    .s_hi (s_hi),
    .t_lo (t_lo),
    .t_hi (t_hi),
    .r_lo (res_lo),
    .r_hi (res_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_lo   <= '0;
      wr_hi   <= '0;
      exc_ri  <= 1'b0;
    end else begin
      wr_en   <= commit;
      wr_addr <= commit ? rd_idx : '0;
      wr_lo   <= commit ? res_lo : '0;
      wr_hi   <= commit ? res_hi : '0;
      exc_ri  <= insn_valid && dec_rsv;
    end
  end
endmodule

// File: rtl/pcopy_simd_unit_sva.sv
module pcopy_simd_unit_sva #(
  parameter int HALF_W = 64,
  parameter int LANE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              insn_valid,
  input logic [31:0]       insn_word,
  input logic [4:0]        dbg_addr,
  input logic [HALF_W-1:0] dbg_lo,
  input logic [HALF_W-1:0] dbg_hi,
  input logic              wr_en,
  input logic [4:0]        wr_addr,
  input logic [HALF_W-1:0] wr_lo,
  input logic [HALF_W-1:0] wr_hi,
  input logic              exc_ri
);
  logic maj_ok, is_spread, is_upack, rs_nz, rt_z;
  assign maj_ok    = insn_word[31:26] == 6'h1C;
  assign is_spread = maj_ok && insn_word[5:0] == 6'h29 && insn_word[10:6] == 5'h1B;
  assign is_upack  = maj_ok && insn_word[5:0] == 6'h29 && insn_word[10:6] == 5'h0E;
  assign rs_nz     = insn_word[25:21] != 5'd0;
  assign rt_z      = insn_word[20:16] == 5'd0;

  assert_no_dual_R8: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && exc_ri));

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(insn_valid) |-> (!wr_en && !exc_ri));

  assert_dest_match_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr == $past(insn_word[15:11])));

  assert_dest_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr != 5'd0));

  assert_rs_field_R3: assert property (@(posedge clk) disable iff (rst)
    $past(insn_valid && is_spread && rs_nz) |-> (exc_ri && !wr_en));

  assert_replicate_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(insn_valid && is_spread)) |->
      (wr_lo[HALF_W-1:LANE_W] == wr_lo[HALF_W-LANE_W-1:0] &&
       wr_hi[HALF_W-1:LANE_W] == wr_hi[HALF_W-LANE_W-1:0]));

  assert_zero_src_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(insn_valid && is_upack && rt_z)) |-> (wr_hi == '0));

  assert_dbg_r0_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(dbg_addr) == 5'd0) |-> (dbg_lo == '0 && dbg_hi == '0));
endmodule

bind pcopy_simd_unit pcopy_simd_unit_sva #(.HALF_W(HALF_W), .LANE_W(LANE_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .insn_valid (insn_valid),
  .insn_word  (insn_word),
  .dbg_addr   (dbg_addr),
  .dbg_lo     (dbg_lo),
  .dbg_hi     (dbg_hi),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_lo      (wr_lo),
  .wr_hi      (wr_hi),
  .exc_ri     (exc_ri)
);

// File: tb/pcopy_simd_unit_tb.sv
`timescale 1ns/1ps
module pcopy_simd_unit_tb;
  localparam int HW = 64;
  localparam logic [5:0] T_MAJ = 6'h1C, T_CB = 6'h09, T_CC = 6'h29;
  localparam logic [4:0] T_SPR = 5'h1B, T_PK = 5'h0E;

  logic clk = 0, rst = 1;
  logic insn_valid = 0;
  logic [31:0] insn_word = '0;
  logic fill_en = 0;
  logic [4:0] fill_addr = '0, dbg_addr = '0;
  logic [HW-1:0] fill_lo = '0, fill_hi = '0;
  logic [HW-1:0] dbg_lo, dbg_hi, wr_lo, wr_hi;
  logic wr_en, exc_ri;
  logic [4:0] wr_addr;

  always #10 clk = ~clk;

  pcopy_simd_unit u_dut (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn_word(insn_word),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_lo(fill_lo), .fill_hi(fill_hi),
    .dbg_addr(dbg_addr), .dbg_lo(dbg_lo), .dbg_hi(dbg_hi),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_lo(wr_lo), .wr_hi(wr_hi), .exc_ri(exc_ri)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [HW-1:0] m_lo [32];
  logic [HW-1:0] m_hi [32];

  typedef struct packed {
    logic we; logic [4:0] a; logic [HW-1:0] lo; logic [HW-1:0] hi; logic exc;
  } exp_t;
  exp_t  q_exp [$];
  string q_tag [$];

  task automatic chk(input string tag, input bit ok, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] c, input logic [4:0] s,
                                     input logic [4:0] rs, input logic [4:0] rt,
                                     input logic [4:0] rd);
    return {T_MAJ, rs, rt, rd, s, c};
  endfunction

  task automatic issue(input logic [31:0] w, input string tag);
    exp_t e;
    logic [4:0] rs, rt, rd;
    logic [HW-1:0] slo, shi, tlo, thi;
    int kind;
    rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
    slo = (rs == 0) ? '0 : m_lo[rs]; shi = (rs == 0) ? '0 : m_hi[rs];
    tlo = (rt == 0) ? '0 : m_lo[rt]; thi = (rt == 0) ? '0 : m_hi[rt];
    kind = 0;
    if (w[31:26] == T_MAJ) begin
      if (w[5:0] == T_CB && w[10:6] == T_PK) kind = 2;
      if (w[5:0] == T_CC && w[10:6] == T_PK) kind = 3;
      if (w[5:0] == T_CC && w[10:6] == T_SPR && rs == 0) kind = 1;
    end
    e = '0;
    e.exc = (kind == 0);
    if (kind != 0 && rd != 0) begin
      e.we = 1; e.a = rd;
      case (kind)
        1: begin e.lo = {4{tlo[15:0]}}; e.hi = {4{thi[15:0]}}; end
        2: begin e.lo = tlo; e.hi = slo; end
        default: begin e.lo = shi; e.hi = thi; end
      endcase
      m_lo[rd] = e.lo; m_hi[rd] = e.hi;
    end
    q_exp.push_back(e);
    q_tag.push_back(tag);
    insn_word = w; insn_valid = 1;
    @(negedge clk);
    insn_valid = 0;
  endtask

  task automatic fill(input logic [4:0] a, input logic [HW-1:0] lo, input logic [HW-1:0] hi);
    fill_en = 1; fill_addr = a; fill_lo = lo; fill_hi = hi;
    if (a != 0) begin m_lo[a] = lo; m_hi[a] = hi; end
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic dchk(input logic [4:0] a, input string tag);
    dbg_addr = a;
    @(negedge clk);
    chk(tag, dbg_lo === m_lo[a] && dbg_hi === m_hi[a], $sformatf("dbg reg %0d", a),
        {dbg_hi, dbg_lo}, {m_hi[a], m_lo[a]});
  endtask

  // monitor: output of each valid word appears one edge later
  logic vld_q = 0;
  always @(posedge clk) vld_q <= rst ? 1'b0 : insn_valid;

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (vld_q) begin
        exp_t e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        chk(t, exc_ri === e.exc, "exc_ri", {127'd0, exc_ri}, {127'd0, e.exc});
        chk(t, wr_en === e.we, "wr_en", {127'd0, wr_en}, {127'd0, e.we});
        if (e.we)
          chk(t, wr_addr === e.a && wr_lo === e.lo && wr_hi === e.hi, "write",
              {wr_addr, wr_hi[58:0], wr_lo}, {e.a, e.hi[58:0], e.lo});
      end else begin
        chk("R9 idle", wr_en === 1'b0 && exc_ri === 1'b0, "idle outputs",
            {126'd0, wr_en, exc_ri}, 128'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", wr_en === 0 && exc_ri === 0, "outputs after reset",
        {126'd0, wr_en, exc_ri}, 128'd0);
    for (int i = 0; i < 32; i++) dchk(i[4:0], "R1 R10");

    fill(5'd1, 64'h1111_2222_3333_A1B2, 64'h4444_5555_6666_C3D4);
    fill(5'd2, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
    fill(5'd3, 64'hDEAD_BEEF_00C0_FFEE, 64'h0BAD_F00D_1234_5678);
    fill(5'd4, 64'hA5A5_A5A5_5A5A_5A5A, 64'h1357_9246_80AC_E000);
    fill(5'd5, 64'hFFFF_0000_FFFF_8001, 64'h0000_0000_FFFF_FFFF);

    // R2 broadcast
    issue(mk(T_CC, T_SPR, 5'd0, 5'd1, 5'd6), "R2 spread r1");
    issue(mk(T_CC, T_SPR, 5'd0, 5'd5, 5'd11), "R2 spread r5");
    dchk(5'd6, "R2 R10");
    // R3 nonzero rs field
    issue(mk(T_CC, T_SPR, 5'd3, 5'd2, 5'd6), "R3 rs nonzero");
    issue(mk(T_CC, T_SPR, 5'd1, 5'd2, 5'd0), "R3 rs nonzero rd0");
    dchk(5'd6, "R3 dest untouched");
    // R4 / R5 packs
    issue(mk(T_CB, T_PK, 5'd2, 5'd3, 5'd7), "R4 lower pack");
    issue(mk(T_CC, T_PK, 5'd4, 5'd5, 5'd8), "R5 upper pack");
    issue(mk(T_CC, T_PK, 5'd7, 5'd7, 5'd12), "R5 same source");
    dchk(5'd7, "R4"); dchk(5'd8, "R5");
    // R7 zero sources
    issue(mk(T_CB, T_PK, 5'd0, 5'd3, 5'd13), "R7 lpack rs0");
    issue(mk(T_CC, T_PK, 5'd4, 5'd0, 5'd14), "R7 upack rt0");
    issue(mk(T_CC, T_SPR, 5'd0, 5'd0, 5'd15), "R7 spread rt0");
    issue(mk(T_CB, T_PK, 5'd0, 5'd0, 5'd1), "R7 both zero");
    dchk(5'd1, "R7");
    // R6 destination zero
    issue(mk(T_CB, T_PK, 5'd2, 5'd3, 5'd0), "R6 lpack rd0");
    issue(mk(T_CC, T_SPR, 5'd0, 5'd2, 5'd0), "R6 spread rd0");
    fill(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_1234_1234_1234);
    dchk(5'd0, "R6 reg0 zero");
    // R8 unrecognised
    issue({6'h1D, 5'd2, 5'd3, 5'd9, T_PK, T_CB}, "R8 bad major");
    issue(mk(6'h08, T_PK, 5'd2, 5'd3, 5'd9), "R8 bad class");
    issue(mk(T_CB, T_SPR, 5'd0, 5'd3, 5'd9), "R8 spread code in pack class");
    issue(mk(T_CC, 5'h00, 5'd2, 5'd3, 5'd9), "R8 unlisted sub");
    dchk(5'd9, "R8 no write");
    // R9 back-to-back dependency
    issue(mk(T_CC, T_SPR, 5'd0, 5'd2, 5'd9), "R9 first");
    issue(mk(T_CB, T_PK, 5'd9, 5'd4, 5'd10), "R9 dependent");
    issue(mk(T_CC, T_PK, 5'd10, 5'd9, 5'd16), "R9 chain");
    dchk(5'd10, "R9"); dchk(5'd16, "R9");
    // R11 fill and instruction to same register
    fill_en = 1; fill_addr = 5'd10; fill_lo = 64'hCAFE; fill_hi = 64'hBEEF;
    m_lo[10] = 64'hCAFE; m_hi[10] = 64'hBEEF;
    issue(mk(T_CB, T_PK, 5'd2, 5'd3, 5'd10), "R11 clash");
    fill_en = 0;
    dchk(5'd10, "R11");
    // R11 fill and instruction to different registers
    fill_en = 1; fill_addr = 5'd17; fill_lo = 64'h7777; fill_hi = 64'h8888;
    m_lo[17] = 64'h7777; m_hi[17] = 64'h8888;
    issue(mk(T_CC, T_PK, 5'd2, 5'd3, 5'd18), "R11 apart");
    fill_en = 0;
    dchk(5'd17, "R11"); dchk(5'd18, "R11");

    repeat (2) @(negedge clk);
    done = 1;
    chk("R9 drain", q_exp.size() == 0, "queue empty", q_exp.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule